// File: doc/BRIEF.md
# Per-Channel Fragment Reassembly Tracker

This block follows packets that arrive as a stream of fixed-size receive fragments spread over up to 32 interleaved channels. Each fragment brings two 32-bit status words. The first word names the channel and carries start and end markers, a byte count, a receive-buffer element index, a receive-error flag and several fatal status flags. The low half of the second word is a partial checksum. For every channel the block keeps a record with a receiving flag, the running length, the running checksum and the handle, base address and capacity of the buffer the packet is going into.

When a packet starts, the block asks a free-buffer queue for a handle and looks up that handle's base address and capacity. For each fragment it publishes the write offset inside the buffer, so that a separate copy engine can move the data. When a packet ends it issues a completion with the channel, the final length, the checksum and the handle. The completion says whether the handle goes to the done queue, in which case a host interrupt pulse follows, or back to the free queue because the packet had a receive error. Malformed traffic, buffer overflow and a full done queue are fatal. The block latches an error code and accepts nothing more until reset.

Top module: `mpkt_reasm`

## Requirements
- R1: At reset every channel is marked not receiving, `err_code` is 0 and `frag_ready` is 1. A start fragment on any channel right after reset is accepted even if that channel was mid-packet before the reset.
- R2: Word-0 field positions are: channel [4:0], receive error [10], end marker [14], start marker [15], byte count [23:16] and element index [30:24]. If any of bits 8, 9, 11 or 12 is set, the result is fatal error code 1. Bit 13 and bit 10 raise no error.
- R3: A fragment whose start marker equals the channel's receiving flag gives fatal error code 2. This covers a start while receiving and a continuation while idle. After a valid fragment the new flag is start XOR old flag XOR end.
- R4: For each valid fragment `seg_valid` pulses once. `seg_offset` is 0 on a start fragment and otherwise the channel's running length, and the running length then grows by the byte count.
- R5: The checksum restarts at 0 on a start fragment and adds word 1 bits [15:0] on every fragment, modulo 2^CSUM_W. The result is reported in `cmp_csum`.
- R6: A start fragment raises exactly one free-queue request, which stays asserted while `fq_handle` is 0 at the handshake. The granted handle's `desc_base` and `desc_cap` are stored for the channel, and `seg_base` reports the base for all of the packet's fragments.
- R7: If the running length after a fragment exceeds the stored capacity, the result is fatal error code 3. A length equal to the capacity is accepted.
- R8: An end fragment produces one completion with channel, length, checksum and handle. `cmp_to_done` is the inverse of the receive-error bit, and `irq` pulses for one cycle right after a completion with `cmp_to_done`=1 is accepted.
- R9: If `done_full` is high when a fragment is committed, the result is fatal error code 4.
- R10: Once an error code is nonzero it stays unchanged until reset. While it is nonzero, `frag_ready`, `seg_valid`, `fq_req_valid` and `cmp_valid` are all low.
- R11: `fq_req_valid` and `cmp_valid`, together with the completion fields, hold steady until their ready inputs are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Block idle and able to take a fragment |
| frag_stat0 | input | 32 | First status word |
| frag_stat1 | input | 32 | Second status word (partial checksum in [15:0]) |
| fq_req_valid | output | 1 | Free-queue handle request |
| fq_req_ready | input | 1 | Free queue answers this cycle |
| fq_handle | input | HND_W | Returned handle, 0 means none available |
| desc_handle | output | HND_W | Handle being looked up |
| desc_base | input | ADDR_W | Base address of `desc_handle` |
| desc_cap | input | LEN_W | Capacity in bytes of `desc_handle` |
| seg_valid | output | 1 | Per-fragment write placement valid |
| seg_offset | output | LEN_W | Byte offset of the fragment in its buffer |
| seg_base | output | ADDR_W | Buffer base address |
| seg_bytes | output | 8 | Fragment byte count |
| seg_elem | output | 7 | Receive element index |
| cmp_valid | output | 1 | Completion offered |
| cmp_ready | input | 1 | Completion accepted |
| cmp_chan | output | 5 | Channel of the finished packet |
| cmp_len | output | LEN_W | Final packet length |
| cmp_csum | output | CSUM_W | Final accumulated checksum |
| cmp_handle | output | HND_W | Buffer handle |
| cmp_to_done | output | 1 | 1: done queue, 0: back to free queue |
| done_full | input | 1 | Done queue is full |
| irq | output | 1 | One-cycle host interrupt pulse |
| err_code | output | 3 | Sticky fatal code: 0 none, 1 status, 2 protocol, 3 overflow, 4 done full |

## Verification
The hardest situation to reach is a channel whose state was built up over several fragments, interleaved with other channels, and which then hits a boundary: exactly full capacity, one byte too many, or a marker out of order. Random traffic spreads legal fragments over all 32 channels with random byte counts, occasional zero handles from the free queue and stalled ready signals. A bench model tracks each channel's flag, length, checksum and buffer. Directed sequences then reset the block and build a specific channel up to the fault, so that every fatal code is reached from known state and its stickiness can be probed.

// File: rtl/mr_pkg.sv
package mr_pkg;

   localparam int CHAN_LSB  = 0;
   localparam int STAT_LSB  = 8;
   localparam logic [7:0] STAT_MASK = 8'h1B;
   localparam int RXERR_BIT = 10;
   localparam int EOP_BIT   = 14;
   localparam int SOP_BIT   = 15;
   localparam int CNT_LSB   = 16;
   localparam int ELEM_LSB  = 24;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_STAT  = 3'd1,
      ERR_PROTO = 3'd2,
      ERR_OVF   = 3'd3,
      ERR_DONE  = 3'd4
   } err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_ALLOC,
      ST_DESC,
      ST_COMMIT,
      ST_CMP,
      ST_FATAL
   } st_e;

   typedef struct packed {
      logic        sop;
      logic        eop;
      logic        rxerr;
      logic        stat_err;
      logic [7:0]  bytes;
      logic [6:0]  elem;
      logic [4:0]  chan;
      logic [15:0] cpart;
   } frag_t;

endpackage

// File: rtl/mr_decode.sv
module mr_decode
   import mr_pkg::*;
(
   input  logic [31:0] stat0,
   input  logic [31:0] stat1,
   output frag_t       frag
);

   logic unused_bits;
   assign unused_bits = ^{stat0[31], stat0[7:5], stat1[31:16]};

   always_comb begin
      frag.chan     = stat0[CHAN_LSB +: 5];
      frag.sop      = stat0[SOP_BIT];
      frag.eop      = stat0[EOP_BIT];
      frag.rxerr    = stat0[RXERR_BIT];
      frag.stat_err = |(stat0[STAT_LSB +: 8] & STAT_MASK);
      frag.bytes    = stat0[CNT_LSB +: 8];
      frag.elem     = stat0[ELEM_LSB +: 7];
      frag.cpart    = stat1[15:0];
   end

endmodule

// File: rtl/mr_chan_store.sv
module mr_chan_store #(
   parameter int NCH    = 32,
   parameter int LEN_W  = 16,
   parameter int CSUM_W = 32,
   parameter int HND_W  = 16,
   parameter int ADDR_W = 32,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   rd_chan,
   output logic              rd_recv,
   output logic [LEN_W-1:0]  rd_len,
   output logic [CSUM_W-1:0] rd_csum,
   output logic [HND_W-1:0]  rd_hnd,
   output logic [ADDR_W-1:0] rd_base,
   output logic [LEN_W-1:0]  rd_cap,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_chan,
   input  logic              wr_recv,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [CSUM_W-1:0] wr_csum,
   input  logic [HND_W-1:0]  wr_hnd,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [LEN_W-1:0]  wr_cap
);

   logic              recv_r [NCH];
   logic [LEN_W-1:0]  len_r  [NCH];
   logic [CSUM_W-1:0] csum_r [NCH];
   logic [HND_W-1:0]  hnd_r  [NCH];
   logic [ADDR_W-1:0] base_r [NCH];
   logic [LEN_W-1:0]  cap_r  [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            recv_r[i] <= 1'b0;
            len_r[i]  <= '0;
            csum_r[i] <= '0;
            hnd_r[i]  <= '0;
            base_r[i] <= '0;
            cap_r[i]  <= '0;
         end
      end else if (wr_en) begin
         recv_r[wr_chan] <= wr_recv;
         len_r[wr_chan]  <= wr_len;
         csum_r[wr_chan] <= wr_csum;
         hnd_r[wr_chan]  <= wr_hnd;
         base_r[wr_chan] <= wr_base;
         cap_r[wr_chan]  <= wr_cap;
      end
   end

   assign rd_recv = recv_r[rd_chan];
   assign rd_len  = len_r[rd_chan];
   assign rd_csum = csum_r[rd_chan];
   assign rd_hnd  = hnd_r[rd_chan];
   assign rd_base = base_r[rd_chan];
   assign rd_cap  = cap_r[rd_chan];

endmodule

// File: rtl/mr_accum.sv
module mr_accum #(
   parameter int LEN_W  = 16,
   parameter int CSUM_W = 32,
   parameter int FOLD   = 0
) (
   input  logic              sop,
   input  logic [LEN_W-1:0]  old_len,
   input  logic [CSUM_W-1:0] old_csum,
   input  logic [7:0]        bytes,
   input  logic [15:0]       cpart,
   output logic [LEN_W-1:0]  offset,
   output logic [LEN_W:0]    sum_len,
   output logic [CSUM_W-1:0] sum_csum
);

   logic [CSUM_W-1:0] base_cs;

   assign offset  = sop ? '0 : old_len;
   assign sum_len = {1'b0, offset} + (LEN_W+1)'(bytes);
   assign base_cs = sop ? '0 : old_csum;

   generate
      if (FOLD == 0) begin : g_wrap
         assign sum_csum = base_cs + CSUM_W'(cpart);
      end else begin : g_fold
         logic [16:0] raw;
         assign raw      = {1'b0, base_cs[15:0]} + {1'b0, cpart};
         assign sum_csum = CSUM_W'(raw[15:0] + 16'(raw[16]));
      end
   endgenerate

endmodule

// File: rtl/mpkt_reasm.sv
module mpkt_reasm
   import mr_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int LEN_W     = 16,
   parameter int CSUM_W    = 32,
   parameter int HND_W     = 16,
   parameter int ADDR_W    = 32,
   parameter int CSUM_FOLD = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frag_valid,
   output logic              frag_ready,
   input  logic [31:0]       frag_stat0,
   input  logic [31:0]       frag_stat1,
   output logic              fq_req_valid,
   input  logic              fq_req_ready,
   input  logic [HND_W-1:0]  fq_handle,
   output logic [HND_W-1:0]  desc_handle,
   input  logic [ADDR_W-1:0] desc_base,
   input  logic [LEN_W-1:0]  desc_cap,
   output logic              seg_valid,
   output logic [LEN_W-1:0]  seg_offset,
   output logic [ADDR_W-1:0] seg_base,
   output logic [7:0]        seg_bytes,
   output logic [6:0]        seg_elem,
   output logic              cmp_valid,
   input  logic              cmp_ready,
   output logic [4:0]        cmp_chan,
   output logic [LEN_W-1:0]  cmp_len,
   output logic [CSUM_W-1:0] cmp_csum,
   output logic [HND_W-1:0]  cmp_handle,
   output logic              cmp_to_done,
   input  logic              done_full,
   output logic              irq,
   output logic [2:0]        err_code
);

   localparam int CH_W = $clog2(NCH);

   generate
      if (NCH < 2 || NCH > 32 || (1 << CH_W) != NCH) begin : g_bad_nch
         $error("NCH must be a power of two from 2 to 32");
      end
      if (LEN_W < 9 || LEN_W > 32) begin : g_bad_len
         $error("LEN_W must lie in 9..32");
      end
      if (CSUM_W < 16) begin : g_bad_csum
         $error("CSUM_W must be at least 16");
      end
      if (CSUM_FOLD != 0 && (CSUM_FOLD != 1 || CSUM_W != 16)) begin : g_bad_fold
         $error("CSUM_FOLD is 0, or 1 with CSUM_W of 16");
      end
      if (HND_W < 1 || ADDR_W < 1) begin : g_bad_hnd
         $error("HND_W and ADDR_W must be positive");
      end
   endgenerate

   st_e               st;
   err_e              err_q;
   logic [31:0]       s0_q, s1_q;
   logic [HND_W-1:0]  hnd_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  cap_q;
   logic [LEN_W-1:0]  cl_len_q;
   logic [CSUM_W-1:0] cl_csum_q;
   logic [HND_W-1:0]  cl_hnd_q;
   logic              irq_q;

   frag_t             frag;

   logic              rd_recv;
   logic [LEN_W-1:0]  rd_len;
   logic [CSUM_W-1:0] rd_csum;
   logic [HND_W-1:0]  rd_hnd;
   logic [ADDR_W-1:0] rd_base;
   logic [LEN_W-1:0]  rd_cap;

   logic [LEN_W-1:0]  acc_off;
   logic [LEN_W:0]    acc_len;
   logic [CSUM_W-1:0] acc_csum;

   logic [HND_W-1:0]  use_hnd;
   logic [ADDR_W-1:0] use_base;
   logic [LEN_W-1:0]  use_cap;
   logic              over_cap;
   logic              commit_ok;

   mr_decode u_dec (
      .stat0 (s0_q),
      .stat1 (s1_q),
      .frag  (frag)
   );

   mr_chan_store #(
      .NCH    (NCH),
      .LEN_W  (LEN_W),
      .CSUM_W (CSUM_W),
      .HND_W  (HND_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_chan (frag.chan[CH_W-1:0]),
      .rd_recv (rd_recv),
      .rd_len  (rd_len),
      .rd_csum (rd_csum),
      .rd_hnd  (rd_hnd),
      .rd_base (rd_base),
      .rd_cap  (rd_cap),
      .wr_en   (commit_ok),
      .wr_chan (frag.chan[CH_W-1:0]),
      .wr_recv (frag.sop ^ rd_recv ^ frag.eop),
      .wr_len  (acc_len[LEN_W-1:0]),
      .wr_csum (acc_csum),
      .wr_hnd  (use_hnd),
      .wr_base (use_base),
      .wr_cap  (use_cap)
   );

   mr_accum #(
      .LEN_W  (LEN_W),
      .CSUM_W (CSUM_W),
      .FOLD   (CSUM_FOLD)
   ) u_acc (
      .sop      (frag.sop),
      .old_len  (rd_len),
      .old_csum (rd_csum),
      .bytes    (frag.bytes),
      .cpart    (frag.cpart),
      .offset   (acc_off),
      .sum_len  (acc_len),
      .sum_csum (acc_csum)
   );

   assign use_hnd   = frag.sop ? hnd_q  : rd_hnd;
   assign use_base  = frag.sop ? base_q : rd_base;
   assign use_cap   = frag.sop ? cap_q  : rd_cap;
   assign over_cap  = acc_len > {1'b0, use_cap};
   assign commit_ok = (st == ST_COMMIT) && !over_cap && !done_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         err_q     <= ERR_NONE;
         s0_q      <= '0;
         s1_q      <= '0;
         hnd_q     <= '0;
         base_q    <= '0;
         cap_q     <= '0;
         cl_len_q  <= '0;
         cl_csum_q <= '0;
         cl_hnd_q  <= '0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (frag_valid) begin
                  s0_q <= frag_stat0;
                  s1_q <= frag_stat1;
                  st   <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (frag.stat_err) begin
                  err_q <= ERR_STAT;
                  st    <= ST_FATAL;
               end else if (frag.sop == rd_recv) begin
                  err_q <= ERR_PROTO;
                  st    <= ST_FATAL;
               end else if (frag.sop) begin
                  st <= ST_ALLOC;
               end else begin
                  st <= ST_COMMIT;
               end
            end
            ST_ALLOC: begin
               if (fq_req_ready && (fq_handle != '0)) begin
                  hnd_q <= fq_handle;
                  st    <= ST_DESC;
               end
            end
            ST_DESC: begin
               base_q <= desc_base;
               cap_q  <= desc_cap;
               st     <= ST_COMMIT;
            end
            ST_COMMIT: begin
               if (over_cap) begin
                  err_q <= ERR_OVF;
                  st    <= ST_FATAL;
               end else if (done_full) begin
                  err_q <= ERR_DONE;
                  st    <= ST_FATAL;
               end else begin
                  cl_len_q  <= acc_len[LEN_W-1:0];
                  cl_csum_q <= acc_csum;
                  cl_hnd_q  <= use_hnd;
                  st        <= frag.eop ? ST_CMP : ST_IDLE;
               end
            end
            ST_CMP: begin
               if (cmp_ready) begin
                  irq_q <= !frag.rxerr;
                  st    <= ST_IDLE;
               end
            end
            default: st <= ST_FATAL;
         endcase
      end
   end

   assign frag_ready   = (st == ST_IDLE);
   assign fq_req_valid = (st == ST_ALLOC);
   assign desc_handle  = hnd_q;
   assign seg_valid    = commit_ok;
   assign seg_offset   = acc_off;
   assign seg_base     = use_base;
   assign seg_bytes    = frag.bytes;
   assign seg_elem     = frag.elem;
   assign cmp_valid    = (st == ST_CMP);
   assign cmp_chan     = frag.chan;
   assign cmp_len      = cl_len_q;
   assign cmp_csum     = cl_csum_q;
   assign cmp_handle   = cl_hnd_q;
   assign cmp_to_done  = !frag.rxerr;
   assign irq          = irq_q;
   assign err_code     = err_q;

endmodule

// File: rtl/mpkt_reasm_chk.sv
module mpkt_reasm_chk #(
   parameter int LEN_W = 16,
   parameter int HND_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frag_ready,
   input logic             fq_req_valid,
   input logic             fq_req_ready,
   input logic             seg_valid,
   input logic             cmp_valid,
   input logic             cmp_ready,
   input logic [LEN_W-1:0] cmp_len,
   input logic [HND_W-1:0] cmp_handle,
   input logic             cmp_to_done,
   input logic             irq,
   input logic [2:0]       err_code
);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |=> (err_code == $past(err_code)));

   // R10
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |-> (!frag_ready && !seg_valid && !fq_req_valid && !cmp_valid));

   // R11
   fq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fq_req_valid && !fq_req_ready) |=> fq_req_valid);

   // R11
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !cmp_ready) |=>
         (cmp_valid && $stable(cmp_len) && $stable(cmp_handle) && $stable(cmp_to_done)));

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cmp_valid && cmp_ready && cmp_to_done));

   // R4
   seg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> !frag_ready);

endmodule

bind mpkt_reasm mpkt_reasm_chk #(
   .LEN_W (LEN_W),
   .HND_W (HND_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frag_ready   (frag_ready),
   .fq_req_valid (fq_req_valid),
   .fq_req_ready (fq_req_ready),
   .seg_valid    (seg_valid),
   .cmp_valid    (cmp_valid),
   .cmp_ready    (cmp_ready),
   .cmp_len      (cmp_len),
   .cmp_handle   (cmp_handle),
   .cmp_to_done  (cmp_to_done),
   .irq          (irq),
   .err_code     (err_code)
);

// File: tb/mpkt_reasm_tb.sv
module mpkt_reasm_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frag_valid = 1'b0;
   logic        frag_ready;
   logic [31:0] frag_stat0 = '0;
   logic [31:0] frag_stat1 = '0;
   logic        fq_req_valid;
   logic        fq_req_ready = 1'b0;
   logic [15:0] fq_handle = '0;
   logic [15:0] desc_handle;
   logic [31:0] desc_base;
   logic [15:0] desc_cap;
   logic        seg_valid;
   logic [15:0] seg_offset;
   logic [31:0] seg_base;
   logic [7:0]  seg_bytes;
   logic [6:0]  seg_elem;
   logic        cmp_valid;
   logic        cmp_ready = 1'b0;
   logic [4:0]  cmp_chan;
   logic [15:0] cmp_len;
   logic [31:0] cmp_csum;
   logic [15:0] cmp_handle;
   logic        cmp_to_done;
   logic        done_full = 1'b0;
   logic        irq;
   logic [2:0]  err_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic        m_recv [32];
   logic [15:0] m_len  [32];
   logic [31:0] m_csum [32];
   logic [15:0] m_hnd  [32];
   logic [31:0] m_base [32];
   logic [15:0] m_cap  [32];

   localparam logic [15:0] SMALL_H = 16'd7;

   always #5 clk = ~clk;

   mpkt_reasm u_dut (
      .clk(clk), .rst_n(rst_n),
      .frag_valid(frag_valid), .frag_ready(frag_ready),
      .frag_stat0(frag_stat0), .frag_stat1(frag_stat1),
      .fq_req_valid(fq_req_valid), .fq_req_ready(fq_req_ready), .fq_handle(fq_handle),
      .desc_handle(desc_handle), .desc_base(desc_base), .desc_cap(desc_cap),
      .seg_valid(seg_valid), .seg_offset(seg_offset), .seg_base(seg_base),
      .seg_bytes(seg_bytes), .seg_elem(seg_elem),
      .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_chan(cmp_chan),
      .cmp_len(cmp_len), .cmp_csum(cmp_csum), .cmp_handle(cmp_handle),
      .cmp_to_done(cmp_to_done), .done_full(done_full), .irq(irq), .err_code(err_code)
   );

   function automatic logic [31:0] base_of(input logic [15:0] h);
      return {8'h00, h, 8'h00};
   endfunction

   function automatic logic [15:0] cap_of(input logic [15:0] h);
      return (h == SMALL_H) ? 16'd100 : 16'd4000;
   endfunction

   function automatic logic [31:0] mk_s0(input logic [4:0] ch, input bit sop, input bit eop,
                                         input bit rx, input logic [7:0] nb, input logic [6:0] el);
      logic [31:0] w;
      w = {1'b0, el, nb, sop, eop, 6'b0, 3'b0, ch};
      w[10] = rx;
      return w;
   endfunction

   always_comb begin
      desc_base = base_of(desc_handle);
      desc_cap  = cap_of(desc_handle);
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      frag_valid   = 1'b0;
      fq_req_ready = 1'b0;
      cmp_ready    = 1'b0;
      done_full    = 1'b0;
      rst_n        = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) begin
         m_recv[i] = 1'b0; m_len[i] = '0; m_csum[i] = '0;
         m_hnd[i] = '0; m_base[i] = '0; m_cap[i] = '0;
      end
   endtask

   task automatic run_frag(input logic [31:0] s0, input logic [31:0] s1,
                           input bit zero_first, input logic [15:0] hpick);
      logic [4:0]  ch;
      bit          sop, eop, rx, stat;
      logic [7:0]  nb;
      logic [6:0]  el;
      logic [2:0]  exp_err;
      logic [15:0] exp_off, exp_h, exp_cap;
      logic [31:0] exp_base, exp_cs;
      int          exp_len, seg_n, alloc_n, cmp_n, w;
      bit          hs, gave_zero;
      string       etag;
      ch = s0[4:0]; sop = s0[15]; eop = s0[14]; rx = s0[10];
      nb = s0[23:16]; el = s0[30:24];
      stat = s0[8] | s0[9] | s0[11] | s0[12];
      exp_off = '0; exp_h = '0; exp_cap = '0; exp_base = '0; exp_cs = '0; exp_len = 0;
      if (stat) exp_err = 3'd1;
      else if (sop == m_recv[ch]) exp_err = 3'd2;
      else begin
         exp_off  = sop ? 16'd0 : m_len[ch];
         exp_len  = int'(exp_off) + int'(nb);
         exp_h    = sop ? hpick : m_hnd[ch];
         exp_base = sop ? base_of(hpick) : m_base[ch];
         exp_cap  = sop ? cap_of(hpick) : m_cap[ch];
         exp_cs   = (sop ? 32'd0 : m_csum[ch]) + {16'd0, s1[15:0]};
         if (exp_len > int'(exp_cap)) exp_err = 3'd3;
         else if (done_full) exp_err = 3'd4;
         else exp_err = 3'd0;
      end
      etag = (exp_err == 3'd1) ? "R2" : (exp_err == 3'd2) ? "R3" :
             (exp_err == 3'd3) ? "R7" : (exp_err == 3'd4) ? "R9" : "R3 R7 R9";

      @(negedge clk);
      frag_valid = 1'b1; frag_stat0 = s0; frag_stat1 = s1;
      w = 0;
      while (!frag_ready && w < 20) begin @(negedge clk); w++; end
      @(posedge clk);
      @(negedge clk);
      frag_valid = 1'b0;

      seg_n = 0; alloc_n = 0; cmp_n = 0; hs = 1'b0; gave_zero = 1'b0;
      for (int k = 0; k < 80; k++) begin
         if (hs) begin
            chk("R8 irq after completion", irq, !rx);
            hs = 1'b0;
         end
         if (frag_ready || err_code != 3'd0) break;
         if (seg_valid) begin
            seg_n++;
            chk("R4 seg_offset", seg_offset, exp_off);
            chk("R6 seg_base", seg_base, exp_base);
            chk("R2 seg_bytes", seg_bytes, nb);
            chk("R2 seg_elem", seg_elem, el);
         end
         if (fq_req_valid) begin
            if ($urandom % 3 != 0) begin
               fq_req_ready = 1'b1;
               if (zero_first && !gave_zero) begin
                  fq_handle = '0; gave_zero = 1'b1;
               end else begin
                  fq_handle = hpick; alloc_n++;
               end
            end else fq_req_ready = 1'b0;
         end else fq_req_ready = 1'b0;
         if (cmp_valid) begin
            chk("R8 R11 cmp_chan", cmp_chan, ch);
            chk("R8 R11 cmp_len", cmp_len, exp_len[15:0]);
            chk("R5 cmp_csum", cmp_csum, exp_cs);
            chk("R8 R11 cmp_handle", cmp_handle, exp_h);
            chk("R8 R11 cmp_to_done", cmp_to_done, !rx);
            cmp_ready = ($urandom % 2) != 0;
            if (cmp_ready) begin cmp_n++; hs = 1'b1; end
         end else cmp_ready = 1'b0;
         @(negedge clk);
      end
      fq_req_ready = 1'b0;
      cmp_ready = 1'b0;

      chk(etag, err_code, exp_err);
      if (exp_err == 3'd0) begin
         chk("R4 one seg pulse", seg_n, 1);
         chk("R6 one granted request", alloc_n, sop ? 1 : 0);
         chk("R8 completion count", cmp_n, eop ? 1 : 0);
         m_recv[ch] = sop ^ m_recv[ch] ^ eop;
         m_len[ch]  = exp_len[15:0];
         m_csum[ch] = exp_cs;
         m_hnd[ch]  = exp_h;
         m_base[ch] = exp_base;
         m_cap[ch]  = exp_cap;
      end
   endtask

   task automatic probe_locked(input logic [2:0] code);
      frag_valid = 1'b1;
      frag_stat0 = mk_s0(5'd1, 1'b1, 1'b1, 1'b0, 8'd4, 7'd0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R10 frag_ready low", frag_ready, 1'b0);
         chk("R10 seg quiet", seg_valid, 1'b0);
         chk("R10 code held", err_code, code);
      end
      frag_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] next_h;
      int          nfr [32];
      void'($urandom(32'd20240611));
      do_reset();
      // R1 reset state
      chk("R1 frag_ready", frag_ready, 1'b1);
      chk("R1 err_code", err_code, 3'd0);
      chk("R1 no request", fq_req_valid, 1'b0);
      chk("R1 no completion", cmp_valid, 1'b0);

      // random interleaved legal traffic
      next_h = 16'd16;
      for (int i = 0; i < 32; i++) nfr[i] = 0;
      for (int n = 0; n < 400; n++) begin
         logic [4:0] ch;
         bit sop, eop, rx;
         ch  = 5'($urandom % 32);
         sop = !m_recv[ch];
         eop = (nfr[ch] >= 6) ? 1'b1 : (($urandom % 3) == 0);
         rx  = eop && (($urandom % 4) == 0);
         run_frag(mk_s0(ch, sop, eop, rx, 8'(1 + $urandom % 64), 7'($urandom)),
                  $urandom, ($urandom % 4) == 0, next_h);
         if (sop) next_h++;
         nfr[ch] = eop ? 0 : nfr[ch] + 1;
         if (err_code != 3'd0) break;
      end

      // R1: reset abandons a half-received packet
      do_reset();
      run_frag(mk_s0(5'd3, 1'b1, 1'b0, 1'b0, 8'd10, 7'd1), 32'h1, 1'b0, 16'd40);
      do_reset();
      run_frag(mk_s0(5'd3, 1'b1, 1'b1, 1'b0, 8'd10, 7'd1), 32'h1, 1'b0, 16'd41);
      chk("R1 restart accepted", err_code, 3'd0);

      // R3: continuation on idle channel, then R10 lock
      do_reset();
      run_frag(mk_s0(5'd5, 1'b0, 1'b0, 1'b0, 8'd8, 7'd2), 32'h0, 1'b0, 16'd50);
      probe_locked(3'd2);
      // R3: start while receiving
      do_reset();
      run_frag(mk_s0(5'd9, 1'b1, 1'b0, 1'b0, 8'd8, 7'd2), 32'h5, 1'b1, 16'd51);
      run_frag(mk_s0(5'd9, 1'b1, 1'b1, 1'b0, 8'd8, 7'd2), 32'h5, 1'b0, 16'd52);

      // R2: each fatal status bit
      foreach (nfr[b]) begin
         if (b == 8 || b == 9 || b == 11 || b == 12) begin
            logic [31:0] s;
            do_reset();
            s = mk_s0(5'd4, 1'b1, 1'b1, 1'b0, 8'd8, 7'd0);
            s[b] = 1'b1;
            run_frag(s, 32'h0, 1'b0, 16'd60);
         end
      end
      probe_locked(3'd1);
      // R2: bit 13 and bit 10 are harmless
      do_reset();
      begin
         logic [31:0] s;
         s = mk_s0(5'd6, 1'b1, 1'b1, 1'b1, 8'd8, 7'd0);
         s[13] = 1'b1;
         run_frag(s, 32'h77, 1'b0, 16'd61);
         chk("R2 benign bits", err_code, 3'd0);
      end

      // R7: exact capacity then one byte past
      do_reset();
      run_frag(mk_s0(5'd2, 1'b1, 1'b0, 1'b0, 8'd60, 7'd3), 32'h10, 1'b0, SMALL_H);
      run_frag(mk_s0(5'd2, 1'b0, 1'b0, 1'b0, 8'd40, 7'd4), 32'h20, 1'b0, 16'd0);
      chk("R7 equal capacity ok", err_code, 3'd0);
      run_frag(mk_s0(5'd2, 1'b0, 1'b1, 1'b0, 8'd1, 7'd5), 32'h30, 1'b0, 16'd0);
      probe_locked(3'd3);

      // R9: done queue full
      do_reset();
      done_full = 1'b1;
      run_frag(mk_s0(5'd8, 1'b1, 1'b1, 1'b0, 8'd12, 7'd6), 32'h9, 1'b1, 16'd70);
      done_full = 1'b0;
      probe_locked(3'd4);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule